// File: doc/BRIEF.md
# Precise Exception Commit Controller

This block tracks exception status for a five-stage in-order pipeline and produces fetch, decode, execute, memory and writeback stages. It owns the fetch program counter and keeps a valid bit, a PC, a pending-exception flag and a cause code for every instruction in flight. Each of the first four stages can flag the instruction it holds. The flag then travels with that instruction. The exception is taken at one commit point, which is the memory stage. Architectural state only changes in the memory and writeback stages. So at that point every older instruction has finished, and no younger one has changed anything yet.

When the block takes an exception, it does the following in the same cycle:
- It blocks the data-memory write of the faulting instruction.
- It kills the faulting instruction and everything younger.
- It saves the faulting instruction's PC as the restart PC, together with its cause.
- It steers fetch to a fixed handler address.

An external interrupt request is sampled only when a valid instruction sits in the memory stage. The interrupt takes that instruction's place: the instruction restarts later at its own PC. A synchronous exception on the same instruction wins over the interrupt.

The trap sequencer has two states:
- **ST_RUN** is the normal state. Interrupts are accepted. The transition *trap_taken* moves the sequencer to ST_SHADOW on any take.
- **ST_SHADOW** masks interrupts while the handler's first instruction fills the pipeline. The transition *handler_boundary* returns to ST_RUN when a valid instruction reaches the memory stage and is not itself trapped.

Top module: `precise_exc_ctrl`

## Requirements
- R1: In reset and in the first cycle after it, `fetch_pc_o` equals the reset PC (0x1000) and `redirect_o`, `retire_valid_o`, `rf_we_o` and `mem_we_o` are low. `epc_o` and `cause_o` are zero.
- R2: While no trap is taken, `fetch_pc_o` increases by 4 every cycle. An instruction fetched in cycle t appears on `retire_pc_o` with `retire_valid_o` high in cycle t+4.
- R3: A flag raised in stage F, D, E or M (bit 0, 1, 2 or 3 of `stg_exc_i`, with cause in bits [4j+3:4j] of `stg_cause_i`) is taken only in the cycle its instruction is in the memory stage, three cycles after fetch. In the next cycle `epc_o` holds that instruction's PC and `cause_o` its code.
- R4: The oldest flagged instruction in program order is taken, whatever stages the flags came from. When one instruction is flagged in several stages, the cause from the earliest stage is kept.
- R5: Every instruction older than the trapped one retires. The trapped one never retires. `mem_we_o` is never high in a trap cycle. `mem_we_o` follows `m_store_req_i` and `rf_we_o` follows `w_rf_req_i` for valid instructions.
- R6: After a trap, the younger instructions in F, D and E are discarded. `retire_valid_o` stays low for the four following cycles, and no second trap occurs in the next cycle.
- R7: The cycle after a trap, `fetch_pc_o` equals the handler address (0x80). The first instruction that retires afterwards is the one at the handler address.
- R8: An interrupt is accepted only when a valid instruction is in the memory stage. It saves that instruction's PC and cause code 0xF. An interrupt with an empty memory stage has no effect.
- R9: A synchronous flag on the memory-stage instruction takes precedence over a simultaneous interrupt, and its own cause is saved.
- R10: After a trap, a held interrupt is ignored until the handler's first instruction has committed. It is then taken on the next valid instruction, one cycle later.
- R11: `epc_o` and `cause_o` change only when a trap is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stg_exc_i | input | 4 | Exception flag for the instruction now in F, D, E, M (bits 0..3) |
| stg_cause_i | input | 16 | Four 4-bit cause codes, one per flagging stage |
| irq_i | input | 1 | External interrupt request |
| m_store_req_i | input | 1 | Memory-stage instruction wants to write data memory |
| w_rf_req_i | input | 1 | Writeback-stage instruction wants to write the register file |
| fetch_pc_o | output | 32 | PC being fetched this cycle |
| redirect_o | output | 1 | Trap taken this cycle; fetch goes to the handler next |
| epc_o | output | 32 | Saved restart PC |
| cause_o | output | 4 | Saved cause code |
| mem_we_o | output | 1 | Gated data-memory write enable |
| rf_we_o | output | 1 | Gated register-file write enable |
| retire_valid_o | output | 1 | A valid instruction is in writeback |
| retire_pc_o | output | 32 | PC of the writeback instruction |

## Verification
The bench places a single fault in each of the four flagging stages and on several instruction positions. For each one it checks the take cycle, the saved PC and cause, and how many stores and retirements happened before the take. A design that took a flag in the stage where it was raised would trap early, and would leave older instructions unretired.

Further cases do the following:
- They flag an older instruction in a later stage together with a younger one in an earlier stage, which catches youngest-first selection.
- They flag one instruction in three stages, which catches a cause being overwritten on its way down the pipeline.
- They collide an interrupt with a synchronous fault, which catches wrong priority.
- They raise an interrupt while the memory stage is empty, and hold an interrupt through a trap. This catches a design that takes it on a bubble, or that traps again before the handler has made progress.

// File: rtl/excctl_pkg.sv
package excctl_pkg;

    // Stage positions: 0 fetch, 1 decode, 2 execute, 3 memory, 4 writeback
    localparam int NUM_STG  = 5;
    localparam int FLAG_STG = NUM_STG - 1;
    localparam int MEM_STG  = NUM_STG - 2;
    localparam int WB_STG   = NUM_STG - 1;

    typedef enum logic {
        ST_RUN,
        ST_SHADOW
    } trap_st_e;

endpackage

// File: rtl/ecc_fetch_pc.sv
module ecc_fetch_pc #(
    parameter int              PCW        = 32,
    parameter logic [PCW-1:0]  RESET_PC   = 32'h0000_1000,
    parameter logic [PCW-1:0]  HANDLER_PC = 32'h0000_0080,
    parameter logic [PCW-1:0]  PC_STEP    = 32'd4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           redirect_i,
    output logic [PCW-1:0] pc_o
);

    logic [PCW-1:0] pc_q;

    always_ff @(posedge clk) begin
        if (!rst_n)          pc_q <= RESET_PC;
        else if (redirect_i) pc_q <= HANDLER_PC;
        else                 pc_q <= pc_q + PC_STEP;
    end

    assign pc_o = pc_q;

    // R7
    handler_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_i |=> (pc_q == HANDLER_PC));

    // R2
    seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !redirect_i |=> (pc_q == $past(pc_q) + PC_STEP));

endmodule

// File: rtl/ecc_stage_pipe.sv
module ecc_stage_pipe
    import excctl_pkg::*;
#(
    parameter int PCW = 32,
    parameter int CW  = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [PCW-1:0]         fetch_pc_i,
    input  logic [FLAG_STG-1:0]    flag_i,
    input  logic [FLAG_STG*CW-1:0] cause_i,
    input  logic                   take_i,
    output logic                   m_vld_o,
    output logic [PCW-1:0]         m_pc_o,
    output logic                   m_exc_o,
    output logic [CW-1:0]          m_cause_o,
    output logic                   w_vld_o,
    output logic [PCW-1:0]         w_pc_o
);

    logic           cur_vld   [NUM_STG];
    logic [PCW-1:0] cur_pc    [NUM_STG];
    logic           cur_exc   [FLAG_STG];
    logic [CW-1:0]  cur_cause [FLAG_STG];
    logic           mrg_exc   [FLAG_STG];
    logic [CW-1:0]  mrg_cause [FLAG_STG];

    // Fetch stage is the instruction at the current fetch PC
    assign cur_vld[0]   = 1'b1;
    assign cur_pc[0]    = fetch_pc_i;
    assign cur_exc[0]   = 1'b0;
    assign cur_cause[0] = '0;

    // Merge each stage's own flag; an earlier-stage cause is never replaced
    for (genvar j = 0; j < FLAG_STG; j++) begin : g_merge
        assign mrg_exc[j]   = cur_exc[j] | (cur_vld[j] & flag_i[j]);
        assign mrg_cause[j] = cur_exc[j] ? cur_cause[j] : cause_i[j*CW +: CW];
    end

    for (genvar k = 1; k < NUM_STG; k++) begin : g_stage
        logic           v_q;
        logic [PCW-1:0] p_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q <= 1'b0;
                p_q <= '0;
            end else begin
                v_q <= cur_vld[k-1] & ~take_i;
                p_q <= cur_pc[k-1];
            end
        end

        assign cur_vld[k] = v_q;
        assign cur_pc[k]  = p_q;

        if (k < FLAG_STG) begin : g_flag
            logic          e_q;
            logic [CW-1:0] c_q;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    e_q <= 1'b0;
                    c_q <= '0;
                end else begin
                    e_q <= mrg_exc[k-1] & cur_vld[k-1] & ~take_i;
                    c_q <= mrg_cause[k-1];
                end
            end

            assign cur_exc[k]   = e_q;
            assign cur_cause[k] = c_q;
        end
    end

    assign m_vld_o   = cur_vld[MEM_STG];
    assign m_pc_o    = cur_pc[MEM_STG];
    assign m_exc_o   = mrg_exc[MEM_STG];
    assign m_cause_o = mrg_cause[MEM_STG];
    assign w_vld_o   = cur_vld[WB_STG];
    assign w_pc_o    = cur_pc[WB_STG];

    // R6
    flush_empties_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> !cur_vld[MEM_STG]);

    // R5
    trapped_never_retires_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> !cur_vld[WB_STG]);

endmodule

// File: rtl/ecc_trap_ctrl.sv
module ecc_trap_ctrl
    import excctl_pkg::*;
#(
    parameter int             PCW       = 32,
    parameter int             CW        = 4,
    parameter logic [CW-1:0]  IRQ_CAUSE = '1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           m_vld_i,
    input  logic [PCW-1:0] m_pc_i,
    input  logic           m_exc_i,
    input  logic [CW-1:0]  m_cause_i,
    input  logic           irq_i,
    input  logic           m_store_req_i,
    output logic           take_o,
    output logic           mem_we_o,
    output logic [PCW-1:0] epc_o,
    output logic [CW-1:0]  cause_o
);

    trap_st_e       st_q, st_d;
    logic           irq_en;
    logic [CW-1:0]  tcause;
    logic [PCW-1:0] epc_q;
    logic [CW-1:0]  cause_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_RUN;
        else        st_q <= st_d;
    end

    // Outputs and next state
    always_comb begin
        st_d   = st_q;
        irq_en = 1'b0;
        unique case (st_q)
            ST_RUN: begin
                irq_en = 1'b1;
            end
            ST_SHADOW: begin
                irq_en = 1'b0;
            end
        endcase
        take_o   = m_vld_i & (m_exc_i | (irq_i & irq_en));
        tcause   = m_exc_i ? m_cause_i : IRQ_CAUSE;
        mem_we_o = m_vld_i & m_store_req_i & ~take_o;
        unique case (st_q)
            ST_RUN:    if (take_o) st_d = ST_SHADOW;          // trap_taken
            ST_SHADOW: if (m_vld_i && !take_o) st_d = ST_RUN; // handler_boundary
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            epc_q   <= '0;
            cause_q <= '0;
        end else if (take_o) begin
            epc_q   <= m_pc_i;
            cause_q <= tcause;
        end
    end

    assign epc_o   = epc_q;
    assign cause_o = cause_q;

    // R5
    no_store_on_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> !take_o);

    // R11
    epc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !take_o |=> ($stable(epc_q) && $stable(cause_q)));

    // R10
    shadow_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> (st_q == ST_SHADOW));

    // R3
    saved_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> (epc_q == $past(m_pc_i)));

endmodule

// File: rtl/precise_exc_ctrl.sv
module precise_exc_ctrl
    import excctl_pkg::*;
#(
    parameter int              PCW        = 32,
    parameter int              CW         = 4,
    parameter logic [PCW-1:0]  RESET_PC   = 32'h0000_1000,
    parameter logic [PCW-1:0]  HANDLER_PC = 32'h0000_0080,
    parameter logic [PCW-1:0]  PC_STEP    = 32'd4,
    parameter logic [CW-1:0]   IRQ_CAUSE  = '1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [FLAG_STG-1:0]    stg_exc_i,
    input  logic [FLAG_STG*CW-1:0] stg_cause_i,
    input  logic                   irq_i,
    input  logic                   m_store_req_i,
    input  logic                   w_rf_req_i,
    output logic [PCW-1:0]         fetch_pc_o,
    output logic                   redirect_o,
    output logic [PCW-1:0]         epc_o,
    output logic [CW-1:0]          cause_o,
    output logic                   mem_we_o,
    output logic                   rf_we_o,
    output logic                   retire_valid_o,
    output logic [PCW-1:0]         retire_pc_o
);

    logic           take;
    logic           m_vld, m_exc, w_vld;
    logic [PCW-1:0] m_pc, w_pc;
    logic [CW-1:0]  m_cause;

    ecc_fetch_pc #(
        .PCW(PCW), .RESET_PC(RESET_PC), .HANDLER_PC(HANDLER_PC), .PC_STEP(PC_STEP)
    ) u_pc (
        .clk(clk), .rst_n(rst_n), .redirect_i(take), .pc_o(fetch_pc_o)
    );

    ecc_stage_pipe #(.PCW(PCW), .CW(CW)) u_pipe (
        .clk(clk), .rst_n(rst_n), .fetch_pc_i(fetch_pc_o),
        .flag_i(stg_exc_i), .cause_i(stg_cause_i), .take_i(take),
        .m_vld_o(m_vld), .m_pc_o(m_pc), .m_exc_o(m_exc), .m_cause_o(m_cause),
        .w_vld_o(w_vld), .w_pc_o(w_pc)
    );

    ecc_trap_ctrl #(.PCW(PCW), .CW(CW), .IRQ_CAUSE(IRQ_CAUSE)) u_trap (
        .clk(clk), .rst_n(rst_n), .m_vld_i(m_vld), .m_pc_i(m_pc),
        .m_exc_i(m_exc), .m_cause_i(m_cause), .irq_i(irq_i),
        .m_store_req_i(m_store_req_i), .take_o(take), .mem_we_o(mem_we_o),
        .epc_o(epc_o), .cause_o(cause_o)
    );

    assign redirect_o     = take;
    assign rf_we_o        = w_vld & w_rf_req_i;
    assign retire_valid_o = w_vld;
    assign retire_pc_o    = w_pc;

    // R6
    no_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |=> !redirect_o);

endmodule

// File: tb/tb_precise_exc_ctrl.sv
`timescale 1ns/1ps
module tb_precise_exc_ctrl;

    localparam logic [31:0] RST_PC = 32'h0000_1000;
    localparam logic [31:0] HND_PC = 32'h0000_0080;
    localparam logic [31:0] NOPC   = 32'hFFFF_FFFF;
    localparam int          NCYC   = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  stg_exc_i = '0;
    logic [15:0] stg_cause_i = '0;
    logic        irq_i = 1'b0;
    logic        m_store_req_i = 1'b1;
    logic        w_rf_req_i = 1'b1;
    logic [31:0] fetch_pc_o, epc_o, retire_pc_o;
    logic        redirect_o, mem_we_o, rf_we_o, retire_valid_o;
    logic [3:0]  cause_o;

    int checks = 0;
    int errors = 0;
    logic [31:0] hist [4];

    always #5 clk = ~clk;

    precise_exc_ctrl dut (
        .clk(clk), .rst_n(rst_n), .stg_exc_i(stg_exc_i), .stg_cause_i(stg_cause_i),
        .irq_i(irq_i), .m_store_req_i(m_store_req_i), .w_rf_req_i(w_rf_req_i),
        .fetch_pc_o(fetch_pc_o), .redirect_o(redirect_o), .epc_o(epc_o),
        .cause_o(cause_o), .mem_we_o(mem_we_o), .rf_we_o(rf_we_o),
        .retire_valid_o(retire_valid_o), .retire_pc_o(retire_pc_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // fp: four 32-bit fault PCs (F,D,E,M; NOPC = none); fc: four causes
    task automatic run_case(input logic [127:0] fp, input logic [15:0] fc,
                            input int irq_lo, input int irq_hi,
                            input int exp_t1, input logic [31:0] exp_epc,
                            input logic [3:0] exp_c, input int exp_t2);
        int t1 = -1;
        int t2 = -1;
        int nret = 0;
        int nmem = 0;
        int n;
        @(negedge clk);
        rst_n = 1'b0; stg_exc_i = '0; irq_i = 1'b0; stg_cause_i = fc;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 4; k++) hist[k] = NOPC;
        for (int c = 0; c < NCYC; c++) begin
            for (int k = 3; k > 0; k--) hist[k] = hist[k-1];
            hist[0] = fetch_pc_o;
            for (int j = 0; j < 4; j++)
                stg_exc_i[j] = (fp[j*32 +: 32] != NOPC) && (hist[j] == fp[j*32 +: 32]);
            irq_i = (c >= irq_lo) && (c <= irq_hi);
            #1;
            if (c == 0) begin
                // R1 state after reset
                chk(fetch_pc_o == RST_PC, "R1", "fetch pc", fetch_pc_o, RST_PC);
                chk(!retire_valid_o && !rf_we_o && !mem_we_o && !redirect_o, "R1",
                    "quiet outputs", {retire_valid_o, rf_we_o, mem_we_o, redirect_o}, 0);
                chk(epc_o == 0 && cause_o == 0, "R1", "epc/cause", epc_o, 0);
            end
            if (redirect_o) begin
                if (t1 < 0) t1 = c;
                else if (t2 < 0) t2 = c;
            end
            if (t1 < 0 || c == t1) begin
                nret += int'(rf_we_o);
                nmem += int'(mem_we_o);
            end
            if (mem_we_o && redirect_o)
                chk(1'b0, "R5", "store in trap cycle", 1, 0);
            if (t1 >= 0 && c == t1 + 1) begin
                chk(fetch_pc_o == HND_PC, "R7", "handler fetch", fetch_pc_o, HND_PC);
                chk(epc_o == exp_epc, "R3", "saved pc", epc_o, exp_epc);
                chk(cause_o == exp_c, "R4", "saved cause", cause_o, exp_c);
            end
            if (t1 >= 0 && c == t1 + 2)
                chk(fetch_pc_o == HND_PC + 4, "R2", "handler step", fetch_pc_o, HND_PC + 4);
            if (t1 >= 0 && c > t1 && c <= t1 + 4)
                chk(!retire_valid_o, "R6", "flushed retire", retire_valid_o, 0);
            if (t1 >= 0 && c == t1 + 5)
                chk(retire_valid_o && retire_pc_o == HND_PC, "R7", "first handler retire",
                    retire_pc_o, HND_PC);
            @(negedge clk);
        end
        chk(t1 == exp_t1, "R3", "take cycle", t1, exp_t1);
        chk(t2 == exp_t2, "R10", "second take cycle", t2, exp_t2);
        if (exp_t1 >= 0) begin
            n = int'((exp_epc - RST_PC) >> 2);
            chk(nret == n, "R5", "older retirements", nret, n);
            chk(nmem == n, "R5", "older stores", nmem, n);
        end else begin
            chk(nret == NCYC - 4, "R2", "retire stream", nret, NCYC - 4);
        end
    endtask

    function automatic logic [127:0] one_fault(input int s, input logic [31:0] pc);
        logic [127:0] v = {4{NOPC}};
        v[s*32 +: 32] = pc;
        return v;
    endfunction

    initial begin
        // R3 R5 R6 R7: single fault swept over stage and position
        for (int s = 0; s < 4; s++) begin
            for (int n = 0; n < 5; n++) begin
                logic [3:0] cc = 4'(s * 3 + n + 1);
                run_case(one_fault(s, RST_PC + 32'(4 * n)), {4{cc}}, -1, -1,
                         n + 3, RST_PC + 32'(4 * n), cc, -1);
            end
        end
        // R4 older in E beats younger in D in the same cycle
        run_case({NOPC, RST_PC + 32'd16, RST_PC + 32'd20, NOPC}, 16'h4325, -1, -1,
                 7, RST_PC + 32'd16, 4'h3, -1);
        // R4 one instruction flagged in D, E and M keeps the decode cause
        run_case({RST_PC + 32'd8, RST_PC + 32'd8, RST_PC + 32'd8, NOPC}, 16'h5327, -1, -1,
                 5, RST_PC + 32'd8, 4'h2, -1);
        // R4 flag in M wins over a younger flag in F
        run_case({RST_PC + 32'd8, NOPC, NOPC, RST_PC + 32'd20}, 16'h5001, -1, -1,
                 5, RST_PC + 32'd8, 4'h5, -1);
        // R8 interrupt with a valid memory-stage instruction
        run_case({4{NOPC}}, 16'h0, 5, 5, 5, RST_PC + 32'd8, 4'hF, -1);
        // R8 interrupt on an empty memory stage has no effect
        run_case({4{NOPC}}, 16'h0, 1, 1, -1, 32'h0, 4'h0, -1);
        // R9 synchronous fault beats interrupt on the same instruction
        run_case({RST_PC + 32'd12, NOPC, NOPC, NOPC}, 16'h6000, 6, 6,
                 6, RST_PC + 32'd12, 4'h6, -1);
        // R10 held interrupt waits for the first handler instruction
        run_case({NOPC, RST_PC + 32'd8, NOPC, NOPC}, 16'h0300, 6, NCYC,
                 5, RST_PC + 32'd8, 4'h3, 10);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule